// File: doc/BRIEF.md
# Guard-Interval Window Capture Ping-Pong Buffer

This block sits beside a four-antenna OFDM receiver and lifts two short windows out of every symbol on all branches: the cyclic-prefix samples at the symbol's start and the samples at the end of the effective part that the prefix repeats. An adaptive combiner running on a processor compares the two windows to work out its weights, so the block hands each completed pair of windows over as one unit. It stores them in a two-bank RAM. The receiver writes one bank on its own clock while the processor reads the other bank on a second, unrelated clock.

A symbol is `NFFT + NFFT/GI_DIV` samples long. With the production setting `NFFT = 8192` and `GI_DIV = 16`, each window holds 512 samples per branch and the whole buffer is 8K words of 32 bits. The defaults are smaller so that the block elaborates quickly. Each word holds the in-phase sample in bits [31:16] and the quadrature sample in bits [15:0].

The processor learns of new data through interrupt pulses, a valid flag and a bank indication. It hands a bank back by dropping its run line. If the receiver reaches a symbol start while the bank it would fill is still held, it skips that symbol and raises a sticky overrun flag.

Top module: `gi_capture_pingpong`

## Requirements
- R1: While reset is high and after it falls, `valid`, `bank_sel`, `overrun`, `irq_head` and `irq_tail` are all 0.
- R2: A symbol begins with the sample on which `smp_valid` and `sym_start` are both high. Its positions 0 to GI-1 on branch b are stored at read address {window=0, branch=b, index=position}. Each word is {I, Q}.
- R3: Positions NFFT to NFFT+GI-1 are stored at {window=1, branch=b, index=position-NFFT}. No other position of the symbol is stored.
- R4: When the last sample of a captured symbol has been written, `irq_tail` pulses high for exactly one `rclk` cycle. `valid` is high in that cycle.
- R5: When `two_irq` is 1, `irq_head` pulses once per captured symbol, after the last head-window sample. When `two_irq` is 0, `irq_head` stays low. `irq_head` and `irq_tail` are never high together.
- R6: Captured symbols fill bank 0, then bank 1, and so on alternately. `bank_sel` names the oldest bank the processor has not yet released, and reads address that bank.
- R7: A falling edge of `run` while `valid` is high releases the `bank_sel` bank and flips `bank_sel` one `rclk` edge later. A falling edge while `valid` is low has no effect.
- R8: A symbol that starts while its destination bank is still held is dropped. It causes no writes and no interrupts, and it sets `overrun`, which stays high until reset.
- R9: Samples with `smp_valid` low are ignored, including their `sym_start`. A new `sym_start` in the middle of a symbol restarts the position count at 0.
- R10: `rd_data` shows the word at `rd_addr` after one `rclk` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Receiver sample clock |
| rst | input | 1 | Asynchronous reset for both clock domains, active high |
| sym_start | input | 1 | Marks the first sample of a symbol |
| smp_valid | input | 1 | Sample qualifier |
| smp_i | input | NBR*SW | In-phase samples, branch b at [b*SW +: SW] |
| smp_q | input | NBR*SW | Quadrature samples, branch b at [b*SW +: SW] |
| rclk | input | 1 | Processor clock |
| rd_addr | input | 1+log2(NBR)+log2(GI) | {window, branch, index} |
| run | input | 1 | Processor busy line; a falling edge releases the bank |
| two_irq | input | 1 | 1: interrupts after head and tail windows; 0: after tail only |
| rd_data | output | 2*SW | Read word {I, Q} |
| bank_sel | output | 1 | Bank the processor should read |
| valid | output | 1 | The `bank_sel` bank holds a complete capture |
| irq_head | output | 1 | One-cycle pulse when a head window is complete |
| irq_tail | output | 1 | One-cycle pulse when a bank is complete |
| overrun | output | 1 | Sticky flag: a symbol was dropped |

## Verification
A wrong position count or wrong window decode stores the wrong samples. This shows up as a mismatch on the first word read back from the affected window, because every stored sample encodes its own position, branch and symbol. A wrong bank pointer or a wrong occupancy bit on either side shows up within a few processor cycles of the next completion or release. The symptoms are `bank_sel` or `valid` disagreeing with the alternating fill order, a dropped symbol that should have been kept, or bank data that a dropped symbol has overwritten.

// File: rtl/gi_capture_pingpong.sv
module gi_capture_pingpong #(
  parameter int NFFT   = 1024,
  parameter int GI_DIV = 16,
  parameter int NBR    = 4,
  parameter int SW     = 16,
  localparam int GI    = NFFT / GI_DIV,
  localparam int IW    = $clog2(GI),
  localparam int BW    = $clog2(NBR),
  localparam int AW    = 1 + BW + IW
) (
  input  logic              wclk,
  input  logic              rst,
  input  logic              sym_start,
  input  logic              smp_valid,
  input  logic [NBR*SW-1:0] smp_i,
  input  logic [NBR*SW-1:0] smp_q,
  input  logic              rclk,
  input  logic [AW-1:0]     rd_addr,
  input  logic              run,
  input  logic              two_irq,
  output logic [2*SW-1:0]   rd_data,
  output logic              bank_sel,
  output logic              valid,
  output logic              irq_head,
  output logic              irq_tail,
  output logic              overrun
);
  localparam int SYM   = NFFT + GI;
  localparam int CW    = $clog2(SYM);
  localparam int DEPTH = 4 * GI;
  localparam logic [CW-1:0] HEAD_END  = CW'(GI - 1);
  localparam logic [CW-1:0] TAIL_BEG  = CW'(NFFT);
  localparam logic [CW-1:0] SYM_LAST  = CW'(SYM - 1);

  logic [2*SW-1:0] mem [NBR][DEPTH];

  // receiver clock domain
  logic [CW-1:0] cnt;
  logic          active, keep, wb, ovr_w, head_t;
  logic [1:0]    fill_t, rel_s1, rel_s2;
  logic [1:0]    rel_t;

  wire           free    = fill_t[wb] == rel_s2[wb];
  wire [CW-1:0]  pos     = sym_start ? '0 : cnt;
  wire           live    = smp_valid && (sym_start || active);
  wire           take    = live && (sym_start ? free : keep);
  wire           in_head = pos <= HEAD_END;
  wire           in_tail = pos >= TAIL_BEG;
  wire           last    = pos == SYM_LAST;

  always_ff @(posedge wclk or posedge rst) begin
    if (rst) begin
      cnt <= '0; active <= 1'b0; keep <= 1'b0; wb <= 1'b0;
      ovr_w <= 1'b0; head_t <= 1'b0; fill_t <= '0;
      rel_s1 <= '0; rel_s2 <= '0;
    end else begin
      rel_s1 <= rel_t;
      rel_s2 <= rel_s1;
      if (live) begin
        cnt    <= pos + 1'b1;
        active <= !last;
        if (sym_start) begin
          keep <= free;
          if (!free) ovr_w <= 1'b1;
        end
        if (take && pos == HEAD_END) head_t <= ~head_t;
        if (take && last) begin
          fill_t[wb] <= ~fill_t[wb];
          wb         <= ~wb;
        end
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (take && (in_head || in_tail))
      for (int b = 0; b < NBR; b++)
        mem[b][{wb, in_tail, pos[IW-1:0]}] <= {smp_i[b*SW +: SW], smp_q[b*SW +: SW]};
  end

  // processor clock domain
  logic [1:0] fill_s1, fill_s2, fill_d;
  logic       head_s1, head_s2, head_d, ovr_s1, ovr_s2, run_q, rb;

  wire occ_rb = fill_s2[rb] != rel_t[rb];
  wire fall   = run_q && !run;

  always_ff @(posedge rclk or posedge rst) begin
    if (rst) begin
      fill_s1 <= '0; fill_s2 <= '0; fill_d <= '0;
      head_s1 <= 1'b0; head_s2 <= 1'b0; head_d <= 1'b0;
      ovr_s1 <= 1'b0; ovr_s2 <= 1'b0; run_q <= 1'b0;
      rel_t <= '0; rb <= 1'b0;
    end else begin
      fill_s1 <= fill_t;  fill_s2 <= fill_s1; fill_d <= fill_s2;
      head_s1 <= head_t;  head_s2 <= head_s1; head_d <= head_s2;
      ovr_s1  <= ovr_w;   ovr_s2  <= ovr_s1;
      run_q   <= run;
      if (fall && occ_rb) begin
        rel_t[rb] <= ~rel_t[rb];
        rb        <= ~rb;
      end
    end
  end

  always_ff @(posedge rclk)
    rd_data <= mem[rd_addr[IW +: BW]][{rb, rd_addr[AW-1], rd_addr[IW-1:0]}];

  assign bank_sel = rb;
  assign valid    = occ_rb;
  assign irq_tail = |(fill_s2 ^ fill_d);
  assign irq_head = two_irq && (head_s2 ^ head_d);
  assign overrun  = ovr_s2;
endmodule

// File: rtl/gi_capture_pingpong_chk.sv
module gi_capture_pingpong_chk (
  input logic rclk,
  input logic rst,
  input logic run,
  input logic bank_sel,
  input logic valid,
  input logic irq_head,
  input logic irq_tail,
  input logic overrun
);
  assert_tail_valid_R4: assert property (@(posedge rclk) disable iff (rst)
    irq_tail |-> valid);

  assert_valid_rise_R4: assert property (@(posedge rclk) disable iff (rst)
    $rose(valid) |-> irq_tail);

  assert_irq_excl_R5: assert property (@(posedge rclk) disable iff (rst)
    !(irq_head && irq_tail));

  assert_bank_swap_R7: assert property (@(posedge rclk) disable iff (rst)
    !$stable(bank_sel) |-> ($past(run, 2) && !$past(run)));

  assert_sticky_ovr_R8: assert property (@(posedge rclk) disable iff (rst)
    overrun |=> overrun);
endmodule

bind gi_capture_pingpong gi_capture_pingpong_chk u_chk (
  .rclk(rclk), .rst(rst), .run(run), .bank_sel(bank_sel), .valid(valid),
  .irq_head(irq_head), .irq_tail(irq_tail), .overrun(overrun)
);

// File: tb/gi_capture_pingpong_tb.sv
module gi_capture_pingpong_tb;
  localparam int NFFT = 1024;
  localparam int GI   = NFFT / 16;
  localparam int SYM  = NFFT + GI;

  logic        wclk = 0, rclk = 0, rst = 1;
  logic        sym_start = 0, smp_valid = 0, run = 0, two_irq = 0;
  logic [63:0] smp_i = '0, smp_q = '0;
  logic [8:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        bank_sel, valid, irq_head, irq_tail, overrun;

  always #2 wclk = ~wclk;
  always #3 rclk = ~rclk;

  gi_capture_pingpong u_dut (
    .wclk(wclk), .rst(rst), .sym_start(sym_start), .smp_valid(smp_valid),
    .smp_i(smp_i), .smp_q(smp_q), .rclk(rclk), .rd_addr(rd_addr), .run(run),
    .two_irq(two_irq), .rd_data(rd_data), .bank_sel(bank_sel), .valid(valid),
    .irq_head(irq_head), .irq_tail(irq_tail), .overrun(overrun)
  );

  int n_chk = 0, n_fail = 0, n_head = 0, n_tail = 0;
  logic [31:0] exp_mem [2][2][4][GI];
  int m_wb = 0, m_rb = 0, m_ovr = 0;
  int m_occ [2] = '{0, 0};

  always @(negedge rclk) if (!rst) begin
    if (irq_head) n_head++;
    if (irq_tail) n_tail++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] word(int s, int b, int n);
    return {16'(n), 16'(s * 16 + b)};
  endfunction

  task automatic drive(int s, int n, bit st);
    @(negedge wclk);
    sym_start = st; smp_valid = 1;
    for (int b = 0; b < 4; b++) begin
      smp_i[b*16 +: 16] = 16'(n);
      smp_q[b*16 +: 16] = 16'(s * 16 + b);
    end
  endtask

  // R9: gap cycles carry sym_start with valid low and junk data
  task automatic gap();
    @(negedge wclk);
    sym_start = 1; smp_valid = 0; smp_i = '1; smp_q = '1;
  endtask

  task automatic send(int s, int len, bit gaps);
    bit cap = (m_occ[m_wb] == 0);
    if (!cap) m_ovr = 1;
    for (int n = 0; n < len; n++) begin
      drive(s, n, n == 0);
      if (cap) for (int b = 0; b < 4; b++) begin
        if (n < GI) exp_mem[m_wb][0][b][n] = word(s, b, n);
        if (n >= NFFT) exp_mem[m_wb][1][b][n - NFFT] = word(s, b, n);
      end
      if (gaps && n % 7 == 3) gap();
    end
    @(negedge wclk);
    sym_start = 0; smp_valid = 0;
    if (cap && len == SYM) begin
      m_occ[m_wb] = 1;
      m_wb ^= 1;
    end
    repeat (8) @(negedge rclk);
  endtask

  task automatic readback(string req);
    for (int w = 0; w < 2; w++)
      for (int b = 0; b < 4; b++)
        for (int i = 0; i < GI; i++) begin
          @(negedge rclk);
          rd_addr = {1'(w), 2'(b), 6'(i)};
          @(negedge rclk);
          chk(req, rd_data, exp_mem[m_rb][w][b][i]);
        end
  endtask

  task automatic release_bank();
    @(negedge rclk); run = 1;
    repeat (2) @(negedge rclk);
    run = 0;
    repeat (4) @(negedge rclk);
    if (m_occ[m_rb] != 0) begin
      m_occ[m_rb] = 0;
      m_rb ^= 1;
    end
    repeat (10) @(negedge wclk);
  endtask

  task automatic status(string req, int eh, int et);
    chk({req, " valid"}, 32'(valid), 32'(m_occ[m_rb]));
    chk({req, " bank_sel"}, 32'(bank_sel), 32'(m_rb));
    chk({req, " overrun"}, 32'(overrun), 32'(m_ovr));
    chk({req, " irq_head count"}, 32'(n_head), 32'(eh));
    chk({req, " irq_tail count"}, 32'(n_tail), 32'(et));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1 chk("R1 valid in reset", 32'(valid), 0);
    chk("R1 overrun in reset", 32'(overrun), 0);
    #30 rst = 0;
    repeat (4) @(negedge rclk);
    status("R1", 0, 0);
    two_irq = 1;
    send(0, SYM, 1);                  // R2 R3 R9 gaps, R4 R5 two-request
    status("R4/R5/R6 sym0", 1, 1);
    readback("R2/R3/R10 sym0 bank0");
    send(1, SYM, 0);                  // R6 second bank
    status("R6 sym1", 2, 2);
    send(2, SYM, 0);                  // R8 both held, dropped
    status("R8 drop", 2, 2);
    readback("R8 bank0 untouched");
    release_bank();
    status("R7 first release", 2, 2);
    readback("R6 bank1 data");
    release_bank();
    status("R7 second release", 2, 2);
    release_bank();                   // R7 no effect when nothing held
    status("R7 idle release", 2, 2);
    two_irq = 0;
    send(5, 100, 0);                  // R9 partial, restarted below
    send(6, SYM, 0);
    status("R5/R9 one-request restart", 2, 3);
    readback("R9 restart data");
    finish_run();
  end
endmodule